// File: doc/BRIEF.md
# I2C target with byte-addressed memory

This block is a two-wire bus target that gives an external controller access to an on-chip byte array. A synchronous system clock samples the SCL and SDA lines. The clock must run at least eight times faster than SCL. From those samples the block finds START and STOP conditions and checks the first byte of each transfer. That byte is the device word: a fixed four-bit type code, then three bits compared with strap inputs, then a direction bit.

A write transfer sends two address bytes and then any number of data bytes. Each data byte goes into the array as soon as its eighth bit arrives, and the address then steps by one. A read transfer returns bytes from an address counter. This counter keeps its value between transfers, so a read can continue where the last access stopped. A random read is done by sending the address as a short write, then a repeated START, then a device word for a read. Both writes and reads wrap from the last location to zero. A write-protect input stops bytes from being stored, but the block still acknowledges them.

The array holds 2^AW bytes. The block ignores every address bit above AW-1 in the two address bytes. The SDA output is open-drain: the block can only pull the line low.

Top module: `i2c_mem_target`

## Requirements
- R1: A START, including a repeated START, always begins a new device word at bit 0. A STOP returns the block to standby with SDA released.
- R2: The device word is sent MSB first. Bits 7:4 must be 1010 and bits 3:1 must equal strap[2:0], with strap[2] compared to bit 3. Bit 0 selects write (0) or read (1). A matching word is acknowledged by holding SDA low for the whole 9th SCL clock.
- R3: If the type code or the strap bits do not match, the block gives no acknowledge and ignores every byte until the next START. The array is not changed.
- R4: In a write, the address high byte comes first and the address low byte second. Address bits above AW-1 are ignored. Each data byte is acknowledged, stored at the current address, and the address then increases by one.
- R5: The address counter wraps from 2^AW-1 to 0, for writes and for reads.
- R6: While wp is high, write data bytes are still acknowledged and the address still advances, but the array is not changed.
- R7: A read that follows the device word directly, with no address bytes, returns the byte at the last accessed address plus one.
- R8: A random read returns the byte at the given address. It is an address-setting write, then a repeated START, then a read device word.
- R9: Read bytes are sent MSB first, and SDA changes only while SCL is low. Reading continues while the controller acknowledges. A NACK from the controller ends the read and releases SDA.
- R10: A STOP that arrives in the middle of a write data byte abandons that byte. The array keeps its old contents at that address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap | input | 3 | Device select code that the device word must match |
| wp | input | 1 | Write protect, active high |
| sda_drive_low | output | 1 | When high, the pad pulls SDA to ground |

## Verification
The address counter can wrap in the same system-clock cycle as a protected write byte. In that cycle the protection gate and the counter increment act together. To provoke this, the bench raises wp and sends a write burst that runs past the last location. It then judges the result with a current-address read, which must return the unchanged byte at the address the counter should reach after wrapping. A second case places a STOP in the middle of a data byte, right after a fresh address load. The next current-address read shows both that the address was set and that the partial byte was dropped.

// File: rtl/i2cmem_pkg.sv
package i2cmem_pkg;

    localparam logic [3:0] TYPE_CODE = 4'b1010;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_AHI,
        ST_ALO,
        ST_WR,
        ST_RD
    } phase_e;

    typedef struct packed {
        logic [3:0] kind;
        logic [2:0] sub;
        logic       rnw;
    } devword_t;

    typedef struct packed {
        logic scl;
        logic sda;
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
    } bus_ev_t;

    function automatic logic dev_match(input devword_t w, input logic [2:0] strap);
        return (w.kind == TYPE_CODE) && (w.sub == strap);
    endfunction

endpackage

// File: rtl/i2cmem_sync.sv
module i2cmem_sync
    import i2cmem_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_p, sda_p;
    logic         scl_q, sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[TOP-1:0], scl_in};
            sda_p <= {sda_p[TOP-1:0], sda_in};
            scl_q <= scl_p[TOP];
            sda_q <= sda_p[TOP];
        end
    end

    always_comb begin
        ev.scl      = scl_p[TOP];
        ev.sda      = sda_p[TOP];
        ev.scl_rise = scl_p[TOP] & ~scl_q;
        ev.scl_fall = ~scl_p[TOP] & scl_q;
        ev.start    = scl_p[TOP] & scl_q & sda_q & ~sda_p[TOP];
        ev.stop     = scl_p[TOP] & scl_q & ~sda_q & sda_p[TOP];
    end

endmodule

// File: rtl/i2cmem_array.sv
module i2cmem_array #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wp,
    input  logic [AW-1:0] addr,
    input  logic          we,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];

    // a store must never reach the array while protection is on
    assert_no_store_protected_R6: assert property (@(posedge clk) disable iff (rst)
        we |-> !wp);

endmodule

// File: rtl/i2cmem_proto.sv
module i2cmem_proto
    import i2cmem_pkg::*;
#(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [2:0]    strap,
    input  logic          wp,
    input  logic [7:0]    rd_data,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [7:0]    wr_data,
    output logic          sda_low
);
    localparam int HI_W = AW - 8;

    phase_e          state, nxt;
    logic [3:0]      cnt;
    logic            in_ack, mack;
    logic [7:0]      shreg;
    logic [HI_W-1:0] ahi;
    devword_t        dw;

    logic active, byte_done, ack_end, store, load_rd;

    always_comb begin
        dw        = devword_t'(shreg);
        active    = (state != ST_IDLE) && !ev.start && !ev.stop;
        byte_done = active && ev.scl_fall && !in_ack && (cnt == 4'd8);
        ack_end   = active && ev.scl_fall && in_ack;
        store     = byte_done && (state == ST_WR);
        load_rd   = ack_end && ((state == ST_RD) ? !mack : (nxt == ST_RD));
        wr_en     = store && !wp;
        wr_data   = shreg;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            nxt     <= ST_IDLE;
            cnt     <= '0;
            in_ack  <= 1'b0;
            mack    <= 1'b1;
            shreg   <= '0;
            ahi     <= '0;
            addr    <= '0;
            sda_low <= 1'b0;
        end else if (ev.stop) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            in_ack  <= 1'b0;
            sda_low <= 1'b0;
        end else if (ev.start) begin
            state   <= ST_DEV;
            cnt     <= '0;
            in_ack  <= 1'b0;
            sda_low <= 1'b0;
        end else if (active) begin
            if (ev.scl_rise) begin
                if (state == ST_RD) begin
                    if (in_ack) mack <= ev.sda;
                    else        cnt  <= cnt + 4'd1;
                end else if (!in_ack) begin
                    shreg <= {shreg[6:0], ev.sda};
                    cnt   <= cnt + 4'd1;
                end
            end
            if (load_rd) begin
                shreg   <= rd_data;
                sda_low <= ~rd_data[7];
                addr    <= addr + 1'b1;
                cnt     <= '0;
                in_ack  <= 1'b0;
                state   <= ST_RD;
            end else if (ack_end) begin
                in_ack  <= 1'b0;
                sda_low <= 1'b0;
                cnt     <= '0;
                state   <= (state == ST_RD) ? ST_IDLE : nxt;
            end else if (byte_done) begin
                unique case (state)
                    ST_DEV: begin
                        if (dev_match(dw, strap)) begin
                            in_ack  <= 1'b1;
                            sda_low <= 1'b1;
                            nxt     <= dw.rnw ? ST_RD : ST_AHI;
                        end else begin
                            state <= ST_IDLE;
                            cnt   <= '0;
                        end
                    end
                    ST_AHI: begin
                        ahi     <= shreg[HI_W-1:0];
                        in_ack  <= 1'b1;
                        sda_low <= 1'b1;
                        nxt     <= ST_ALO;
                    end
                    ST_ALO: begin
                        addr    <= {ahi, shreg};
                        in_ack  <= 1'b1;
                        sda_low <= 1'b1;
                        nxt     <= ST_WR;
                    end
                    ST_WR: begin
                        addr    <= addr + 1'b1;
                        in_ack  <= 1'b1;
                        sda_low <= 1'b1;
                        nxt     <= ST_WR;
                    end
                    ST_RD: begin
                        in_ack  <= 1'b1;
                        sda_low <= 1'b0;
                    end
                    default: ;
                endcase
            end else if (ev.scl_fall && (state == ST_RD) && !in_ack) begin
                shreg   <= {shreg[6:0], 1'b0};
                sda_low <= ~shreg[6];
            end
        end
    end

    // the pad may only move while the synchronised clock line is low
    assert_sda_moves_scl_low_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(sda_low) |-> !ev.scl);

    // standby never holds the line
    assert_idle_released_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_low);

    // in receive phases the line is only pulled during the acknowledge slot
    assert_ack_slot_only_R2: assert property (@(posedge clk) disable iff (rst)
        (sda_low && state != ST_RD) |-> in_ack);

    // every stored or fetched byte moves the counter by exactly one, modulo the depth
    assert_addr_step_R5: assert property (@(posedge clk) disable iff (rst)
        (store || load_rd) |=> (addr == $past(addr) + 1'b1));

endmodule

// File: rtl/i2c_mem_target.sv
module i2c_mem_target
    import i2cmem_pkg::*;
#(
    parameter int AW          = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [2:0] strap,
    input  logic       wp,
    output logic       sda_drive_low
);
    bus_ev_t       ev;
    logic [AW-1:0] addr;
    logic          wr_en;
    logic [7:0]    wr_data, rd_data;

    i2cmem_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    i2cmem_proto #(.AW(AW)) u_proto (
        .clk     (clk),
        .rst     (rst),
        .ev      (ev),
        .strap   (strap),
        .wp      (wp),
        .rd_data (rd_data),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .sda_low (sda_drive_low)
    );

    i2cmem_array #(.AW(AW)) u_array (
        .clk   (clk),
        .rst   (rst),
        .wp    (wp),
        .addr  (addr),
        .we    (wr_en),
        .wdata (wr_data),
        .rdata (rd_data)
    );

endmodule

// File: tb/i2c_mem_target_tb.sv
module i2c_mem_target_tb;
    localparam int AW    = 11;
    localparam int DEPTH = 1 << AW;
    localparam int MASK  = DEPTH - 1;
    localparam int Q     = 8;
    localparam logic [2:0] STRAP = 3'b101;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1, sda_m = 1'b1, wp_m = 1'b0;
    logic sda_drive_low;
    wire  sda_line = sda_m & ~sda_drive_low;

    always #2.5 clk = ~clk;

    i2c_mem_target #(.AW(AW)) u_dut (
        .clk           (clk),
        .rst           (rst),
        .scl_in        (scl_m),
        .sda_in        (sda_line),
        .strap         (STRAP),
        .wp            (wp_m),
        .sda_drive_low (sda_drive_low)
    );

    int   n_chk = 0, n_bad = 0;
    bit   done = 1'b0;
    logic [7:0] model [DEPTH];
    logic [7:0] wbuf [8];
    int   ptr = 0;

    function automatic logic [7:0] dev(input logic rnw);
        return {4'b1010, STRAP, rnw};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] d, output logic ack);
        for (int i = 7; i >= 0; i--) put_bit(d[i]);
        sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = sda_line; wq(); scl_m = 1'b0; wq();
    endtask

    task automatic get_byte(input logic nak, output logic [7:0] d);
        sda_m = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            wq(); scl_m = 1'b1; wq(); d = {d[6:0], sda_line}; wq(); scl_m = 1'b0; wq();
        end
        put_bit(nak);
    endtask

    task automatic set_addr(input logic [15:0] raw);
        logic a;
        put_byte(dev(1'b0), a); chk(a == 1'b0, "R2 write device word ack", a, 0);
        put_byte(raw[15:8], a); chk(a == 1'b0, "R4 address high ack", a, 0);
        put_byte(raw[7:0], a);  chk(a == 1'b0, "R4 address low ack", a, 0);
    endtask

    task automatic wr_txn(input logic [15:0] raw, input int n, input string req);
        logic a;
        int base = int'(raw) & MASK;
        bus_start();
        set_addr(raw);
        for (int i = 0; i < n; i++) begin
            put_byte(wbuf[i], a);
            chk(a == 1'b0, req, a, 0);
            if (!wp_m) model[(base + i) & MASK] = wbuf[i];
        end
        ptr = (base + n) & MASK;
        bus_stop();
    endtask

    task automatic read_body(input int n, input string req);
        logic [7:0] d;
        for (int i = 0; i < n; i++) begin
            get_byte(i == n - 1, d);
            chk(d == model[ptr], req, d, model[ptr]);
            ptr = (ptr + 1) & MASK;
        end
    endtask

    task automatic rd_rand(input logic [15:0] raw, input int n, input string req);
        logic a;
        bus_start();
        set_addr(raw);
        ptr = int'(raw) & MASK;
        bus_start();
        put_byte(dev(1'b1), a); chk(a == 1'b0, "R1 repeated start read word ack", a, 0);
        read_body(n, req);
        bus_stop();
    endtask

    task automatic rd_cur(input int n, input string req);
        logic a;
        bus_start();
        put_byte(dev(1'b1), a); chk(a == 1'b0, "R2 read device word ack", a, 0);
        read_body(n, req);
        bus_stop();
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic a;
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        chk(sda_drive_low == 1'b0, "R1 released after reset", sda_drive_low, 0);

        // prefill low region and a second block
        for (int i = 0; i < 8; i++) wbuf[i] = 8'(8'h30 + i * 7);
        wr_txn(16'h0000, 8, "R4 burst data ack");
        for (int i = 0; i < 4; i++) wbuf[i] = 8'(8'hA0 + i);
        wr_txn(16'h0020, 4, "R4 burst data ack");
        for (int i = 0; i < 6; i++) wbuf[i] = 8'(8'h5C ^ (i * 19));
        wr_txn(16'h0100, 6, "R4 burst data ack");

        // random then sequential then current-address
        rd_rand(16'h0100, 4, "R8 random read then R9 sequential");
        chk(sda_drive_low == 1'b0, "R9 released after NACK", sda_drive_low, 0);
        rd_cur(1, "R7 current address read");
        rd_rand(16'h0003, 1, "R8 random read");
        rd_cur(2, "R7 current address after random read");

        // upper address bits ignored
        wbuf[0] = 8'h77; wbuf[1] = 8'h88;
        wr_txn(16'hFD45, 2, "R4 data ack with junk high bits");
        rd_rand(16'(16'hFD45 & MASK), 2, "R4 upper address bits ignored");

        // wrap on write and read
        wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h33;
        wr_txn(16'(DEPTH - 2), 3, "R5 data ack across end");
        rd_rand(16'(DEPTH - 1), 3, "R5 read wraps to zero");

        // protected burst wrapping at the top
        wp_m = 1'b1;
        for (int i = 0; i < 3; i++) wbuf[i] = 8'(8'hE0 + i);
        wr_txn(16'(DEPTH - 1), 3, "R6 protected byte still acked");
        wp_m = 1'b0;
        rd_cur(1, "R6 protected wrap leaves array and advances counter");
        rd_rand(16'(DEPTH - 1), 2, "R6 protected bytes not stored");

        // strap mismatch and type mismatch
        for (int k = 0; k < 2; k++) begin
            logic [7:0] bad = (k == 0) ? {4'b1010, 3'b100, 1'b0} : {4'b1011, STRAP, 1'b0};
            bus_start();
            put_byte(bad, a);        chk(a == 1'b1, "R3 mismatch word not acked", a, 1);
            put_byte(8'h00, a);      chk(a == 1'b1, "R3 following byte ignored", a, 1);
            put_byte(8'h20, a);
            put_byte(8'hFF, a);      chk(a == 1'b1, "R3 data byte ignored", a, 1);
            bus_stop();
            rd_rand(16'h0020, 1, "R3 array unchanged after mismatch");
        end

        // STOP in the middle of a data byte
        bus_start();
        set_addr(16'h0021);
        for (int i = 0; i < 4; i++) put_bit(1'b0);
        bus_stop();
        ptr = 16'h0021;
        chk(sda_drive_low == 1'b0, "R1 STOP releases line", sda_drive_low, 0);
        rd_cur(1, "R10 partial byte not stored");

        // constrained random bursts
        for (int it = 0; it < 12; it++) begin
            int base = int'($urandom % DEPTH);
            int n    = 1 + int'($urandom % 4);
            logic [15:0] raw = {5'($urandom), 11'(base)};
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_txn(raw, n, "R4 random burst ack");
            rd_rand(16'(base), n, "R4 random burst readback");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule